// File: doc/BRIEF.md
# Consumer Clock Source Mux and Post-Divider

This block feeds up to six on-chip clock consumers. Each consumer owns a small configuration field inside one shared 32-bit control word. The field picks one of two kinds of source: the auxiliary PLL, or one of six frequency-generator outputs. It can also pick no source at all. The field then sets a coarse post-divide factor for the chosen source.

Sources arrive as single-cycle qualified enable strobes in the block's clock domain. Each consumer produces its own single-cycle enable strobe, which a downstream clock gate or enable tree uses. A status bit shows which consumers currently have a source.

The divide code is decoded through a small non-monotonic table. A parameter chooses between two tables:
- the base table, where code 2 gives a plain pass-through;
- the extended table, which adds divide-by-3 on code 2.

Top module: `clk_consumer_mux`

## Requirements
- R1: During and after reset, before any write, the control word reads as zero, every consumer strobe is low and every status bit is low.
- R2: A write stores bits [29:0] of the write data. The stored word appears on the read port in the cycle after the write. Bits [31:30] always read as zero.
- R3: Consumer i uses control bits [5i+4:5i]. Within that field, bits [4:2] are the 3-bit source code and bits [1:0] are the 2-bit divide code.
- R4: Source code 0 disables the consumer. Its strobe stays low whatever the source inputs do, and its divide counter is held at zero.
- R5: Source code 1 selects the auxiliary PLL strobe. Source codes 2 to 7 select generator strobes 0 to 5.
- R6: With the base table, divide codes 0, 1, 2 and 3 divide by 1, 4, 1 and 2.
- R7: With the extended table, divide codes 0, 1, 2 and 3 divide by 1, 4, 3 and 2.
- R8: With divisor N, the consumer strobe rises for one cycle on every Nth strobe of the selected source. It rises in the cycle after that source strobe. Counting starts from the first source strobe after reset or after the last write.
- R9: The status bit of a consumer is high exactly when its stored source code is non-zero.
- R10: A write clears the divide phase of every consumer. In the cycle after a write, every consumer strobe is low, even when source strobes were present in the write cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 32 | Write data for the control word |
| cfg_rdata | output | 32 | Current control word |
| aux_tick | input | 1 | Qualified enable strobe of the auxiliary PLL |
| fg_tick | input | 6 | Qualified enable strobes of the six frequency generators |
| cons_tick | output | 6 | Per-consumer divided enable strobe |
| cons_on | output | 6 | Per-consumer source-present status |

## Verification
The embedded assertions check several properties on every cycle:
- a consumer with source code 0 emits nothing in the next cycle;
- every consumer strobe is preceded by a strobe of its source;
- divide-by-1 passes each source strobe straight through;
- the divide counter never reaches its divisor;
- a write silences all strobes in the following cycle;
- a write lands on the read port.

Only the bench scenarios can show the rest. These are the exact decode of each source code to its input, the divisor each table gives per code, and the pulse phase over long runs of irregular source strobes. The bench sweeps every source and divide code across all consumers for both table variants, using a reference model.

// File: rtl/csmux_pkg.sv
`timescale 1ns/1ps
package csmux_pkg;

  localparam int FIELD_W = 5;
  localparam int SEL_W   = 3;
  localparam int DCODE_W = 2;
  localparam int DIV_W   = 3;

  typedef struct packed {
    logic [SEL_W-1:0]   src;
    logic [DCODE_W-1:0] dcode;
  } cons_field_t;

  // Divide-code decode; code 2 differs between the two table variants.
  function automatic logic [DIV_W-1:0] div_lookup(input logic [DCODE_W-1:0] code,
                                                  input bit ext);
    logic [DIV_W-1:0] d;
    case (code)
      2'd0:    d = 3'd1;
      2'd1:    d = 3'd4;
      2'd2:    d = ext ? 3'd3 : 3'd1;
      default: d = 3'd2;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/csmux_reg.sv
`timescale 1ns/1ps
module csmux_reg #(
  parameter int NUM_CONS = 6,
  parameter int REG_W    = 32
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   wr_en,
  input  logic [REG_W-1:0]                       wr_data,
  output logic [NUM_CONS*csmux_pkg::FIELD_W-1:0] cfg_o,
  output logic [REG_W-1:0]                       rd_data
);
  localparam int FIELDS_W = NUM_CONS * csmux_pkg::FIELD_W;

  logic [FIELDS_W-1:0] cfg_q, cfg_d;
  logic                unused_hi;

  assign unused_hi = ^wr_data[REG_W-1:FIELDS_W];

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data[FIELDS_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assign cfg_o   = cfg_q;
  assign rd_data = REG_W'(cfg_q);

  AST_REG_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == REG_W'($past(wr_data[FIELDS_W-1:0]))); // R2

endmodule

// File: rtl/csmux_sel.sv
`timescale 1ns/1ps
module csmux_sel #(
  parameter int NUM_FG = 6
) (
  input  logic [csmux_pkg::SEL_W-1:0] sel,
  input  logic                        aux_en,
  input  logic [NUM_FG-1:0]           fg_en,
  output logic                        src_en,
  output logic                        active_o
);
  localparam int FG_BASE = 2;

  always_comb begin
    src_en = 1'b0;
    if (sel == 3'd1) src_en = aux_en;
    for (int g = 0; g < NUM_FG; g++) begin
      if (int'(sel) == g + FG_BASE) src_en = fg_en[g];
    end
  end

  assign active_o = (sel != '0);

endmodule

// File: rtl/csmux_div.sv
`timescale 1ns/1ps
module csmux_div #(
  parameter bit EXT_DIV = 1'b1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          src_active,
  input  logic                          src_en,
  input  logic [csmux_pkg::DCODE_W-1:0] dcode,
  input  logic                          restart,
  output logic                          pulse_o
);
  import csmux_pkg::*;

  localparam int CNT_W = 2;

  logic [DIV_W-1:0] div;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             cnt_ld;
  logic             at_last;

  assign div     = div_lookup(dcode, EXT_DIV);
  assign at_last = ({1'b0, cnt_q} == (div - 3'd1));
  assign cnt_ld  = restart || !src_active || src_en;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (restart || !src_active) begin
      cnt_d = '0;
    end else if (src_en) begin
      if (at_last) begin
        cnt_d   = '0;
        pulse_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;

  AST_DIV_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !src_active |=> !pulse_o); // R4
  AST_DIV_PULSE_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> $past(src_en)); // R8
  AST_DIV_BY_ONE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_active && src_en && !restart && div == 3'd1) |=> pulse_o); // R6
  AST_DIV_CNT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, cnt_q} < div); // R7

endmodule

// File: rtl/clk_consumer_mux.sv
`timescale 1ns/1ps
module clk_consumer_mux #(
  parameter int NUM_CONS = 6,
  parameter int NUM_FG   = 6,
  parameter int REG_W    = 32,
  parameter bit EXT_DIV  = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [REG_W-1:0]    cfg_wdata,
  output logic [REG_W-1:0]    cfg_rdata,
  input  logic                aux_tick,
  input  logic [NUM_FG-1:0]   fg_tick,
  output logic [NUM_CONS-1:0] cons_tick,
  output logic [NUM_CONS-1:0] cons_on
);
  import csmux_pkg::*;

  localparam int FIELDS_W = NUM_CONS * FIELD_W;

  logic [FIELDS_W-1:0] cfg;

  csmux_reg #(.NUM_CONS(NUM_CONS), .REG_W(REG_W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wdata),
    .cfg_o   (cfg),
    .rd_data (cfg_rdata)
  );

  for (genvar i = 0; i < NUM_CONS; i++) begin : g_cons
    cons_field_t fld;
    logic        src_en;
    logic        active;

    assign fld = cons_field_t'(cfg[i*FIELD_W +: FIELD_W]);

    csmux_sel #(.NUM_FG(NUM_FG)) u_sel (
      .sel      (fld.src),
      .aux_en   (aux_tick),
      .fg_en    (fg_tick),
      .src_en   (src_en),
      .active_o (active)
    );

    csmux_div #(.EXT_DIV(EXT_DIV)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_active (active),
      .src_en     (src_en),
      .dcode      (fld.dcode),
      .restart    (cfg_wr),
      .pulse_o    (cons_tick[i])
    );

    assign cons_on[i] = active;
  end

  AST_WRITE_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> cons_tick == '0); // R10
  AST_TICK_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (cons_tick & ~$past(cons_on)) == '0); // R9

endmodule

// File: tb/clk_consumer_mux_tb.sv
`timescale 1ns/1ps
module clk_consumer_mux_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_wr;
  logic [31:0] cfg_wdata;
  logic [31:0] rd_x, rd_b;
  logic        aux_tick;
  logic [5:0]  fg_tick;
  logic [5:0]  tick_x, tick_b, on_x, on_b;

  int checks   = 0;
  int failures = 0;

  logic [29:0] cfg_m;
  int          cnt_x [6];
  int          cnt_b [6];
  logic [5:0]  exp_x, exp_b;
  logic [15:0] lfsr;

  clk_consumer_mux #(.EXT_DIV(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_x), .aux_tick(aux_tick), .fg_tick(fg_tick),
    .cons_tick(tick_x), .cons_on(on_x)
  );

  clk_consumer_mux #(.EXT_DIV(1'b0)) u_dut_base (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(rd_b), .aux_tick(aux_tick), .fg_tick(fg_tick),
    .cons_tick(tick_b), .cons_on(on_b)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic int divisor(input int code, input bit ext);
    case (code)
      0: return 1;
      1: return 4;
      2: return ext ? 3 : 1;
      default: return 2;
    endcase
  endfunction

  function automatic bit src_bit(input int s, input logic a, input logic [5:0] f);
    if (s == 0) return 1'b0;
    if (s == 1) return a;
    return f[s-2];
  endfunction

  // Reference step for one cycle of source strobes.
  task automatic model_step();
    for (int i = 0; i < 6; i++) begin
      int s, c;
      bit e;
      s = int'(cfg_m[5*i+2 +: 3]);
      c = int'(cfg_m[5*i +: 2]);
      e = src_bit(s, aux_tick, fg_tick);
      exp_x[i] = 1'b0;
      exp_b[i] = 1'b0;
      if (e) begin
        if (cnt_x[i] == divisor(c, 1'b1) - 1) begin exp_x[i] = 1'b1; cnt_x[i] = 0; end
        else cnt_x[i]++;
        if (cnt_b[i] == divisor(c, 1'b0) - 1) begin exp_b[i] = 1'b1; cnt_b[i] = 0; end
        else cnt_b[i]++;
      end
    end
  endtask

  function automatic string tag_of(input int i, input bit ext);
    int s, c;
    s = int'(cfg_m[5*i+2 +: 3]);
    c = int'(cfg_m[5*i +: 2]);
    if (s == 0) return "R4";
    if (c == 2) return ext ? "R7" : "R6";
    if (s >= 2) return "R5";
    return "R8";
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    cfg_wr    = 1'b1;
    cfg_wdata = w;
    aux_tick  = 1'b1;
    fg_tick   = '1;
    @(posedge clk);
    @(negedge clk);
    cfg_wr   = 1'b0;
    aux_tick = 1'b0;
    fg_tick  = '0;
    cfg_m    = w[29:0];
    for (int i = 0; i < 6; i++) begin cnt_x[i] = 0; cnt_b[i] = 0; end
    check(tick_x == 6'd0 && tick_b == 6'd0, "R10 write silences", {tick_x, tick_b}, 0);
    check(rd_x == {2'b00, w[29:0]}, "R2 readback", rd_x, {2'b00, w[29:0]});
    for (int i = 0; i < 6; i++)
      check(on_x[i] == (w[5*i+2 +: 3] != 3'd0) && on_b[i] == on_x[i],
            "R9 R3 status bit", on_x[i], (w[5*i+2 +: 3] != 3'd0));
  endtask

  task automatic run_cycle(input logic a, input logic [5:0] f);
    aux_tick = a;
    fg_tick  = f;
    model_step();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      check(tick_x[i] == exp_x[i], {tag_of(i, 1'b1), " ext tick"}, tick_x[i], exp_x[i]);
      check(tick_b[i] == exp_b[i], {tag_of(i, 1'b0), " base tick"}, tick_b[i], exp_b[i]);
    end
  endtask

  initial begin
    #1ms;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    cfg_wr    = 1'b0;
    cfg_wdata = '0;
    aux_tick  = 1'b1;
    fg_tick   = '1;
    cfg_m     = '0;
    lfsr      = 16'hACE1;
    for (int i = 0; i < 6; i++) begin cnt_x[i] = 0; cnt_b[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state, with strobes active on all sources
    check(rd_x == 0 && rd_b == 0, "R1 reset word", rd_x, 0);
    check(tick_x == 0 && tick_b == 0, "R1 reset ticks", {tick_x, tick_b}, 0);
    check(on_x == 0 && on_b == 0, "R1 reset status", {on_x, on_b}, 0);
    rst_n = 1'b1;
    run_cycle(1'b1, 6'h3F);
    check(on_x == 0, "R1 status after release", on_x, 0);

    // R2: upper bits read as zero
    write_cfg(32'hFFFF_FFFF);
    check(rd_x[31:30] == 2'b00, "R2 top bits zero", rd_x[31:30], 0);

    // R5: each source code routes its own input only
    for (int g = 1; g < 8; g++) begin
      write_cfg({2'b00, 25'd0, 3'(g), 2'd0});
      for (int k = 0; k < 7; k++) begin
        logic a;
        logic [5:0] f;
        a = (k == 0);
        f = (k == 0) ? 6'd0 : 6'(1 << (k - 1));
        run_cycle(a, f);
        check(tick_x[0] == ((g - 1) == k), "R5 routing", tick_x[0], ((g - 1) == k));
      end
    end

    // R3 R6 R7 R8: sweep every source and divide code over all consumers
    for (int s = 0; s < 8; s++) begin
      for (int c = 0; c < 4; c++) begin
        logic [31:0] w;
        w = '0;
        for (int i = 0; i < 6; i++) begin
          w[5*i+2 +: 3] = 3'((s + i) % 8);
          w[5*i +: 2]   = 2'((c + i) % 4);
        end
        write_cfg(w);
        for (int k = 0; k < 30; k++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          run_cycle(lfsr[0], lfsr[6:1]);
        end
      end
    end

    // R8 R7: steady strobes give exact pulse spacing
    write_cfg({2'b00, 5'b00110, 5'b00111, 5'b00101, 5'b00100, 5'b00111, 5'b00110});
    for (int k = 0; k < 24; k++) run_cycle(1'b1, 6'h3F);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule